// File: doc/BRIEF.md
# Prescaled Event Timer/Counter with Sticky Overflow Flag

This block counts either edges on an asynchronous event pin or ticks of an internal time base. The time base fires once every `TB_DIV` system clocks. The selected pulses pass through a power-of-two prescaler, which can also be bypassed, and then drive a count register. The count register runs as 8 bits or as 16 bits. When the count wraps from all ones to zero, a sticky overflow flag is set. An interrupt line follows that flag through an enable bit.

Software preloads a start value. The number of source pulses between flags is then the prescale ratio times (rollover value minus preset). The count never reloads itself, so software must write the preset again after each overflow. Software can poll the count at any time.

In 16-bit mode the two byte halves are accessed atomically. A read of the low byte captures the high byte into a buffer. A write of the high byte waits in a buffer until the low byte is written.

Top module: `evt_timer`

## Requirements
- R1: After reset, every register reads zero: control (address 0), count low (1), count high buffer (2) and status (3). The interrupt output is low.
- R2: When control bit 2 is 1, the source is the event pin, sampled through a two-stage synchroniser. Control bit 3 picks the edge that counts: 0 counts rising edges, 1 counts falling edges.
- R3: When control bit 2 is 0, the source is the internal time base, which gives one pulse every `TB_DIV` (default 4) clocks.
- R4: Control bits 7:5 hold a value s that sets the prescale ratio to 2^(s+1), from 1:2 up to 1:256. When control bit 4 is 1, the prescaler is bypassed and the ratio is 1:1.
- R5: When control bit 1 is 0 (8-bit mode), the count steps by one per prescaled pulse and wraps from 255 to 0. That wrap sets the overflow flag. The upper byte of the count stays zero.
- R6: When control bit 1 is 1 (16-bit mode), the count wraps from 65535 to 0 and sets the flag.
- R7: The overflow flag (status bit 0) stays set until software writes status with bit 0 equal to 1. If an overflow and a clear arrive in the same cycle, the flag is set.
- R8: The interrupt output equals the overflow flag ANDed with status bit 1 (interrupt enable).
- R9: When control bit 0 (run) is 0, the count holds its value.
- R10: A read of address 1 copies the high byte of the count into a buffer. Address 2 returns that buffer.
- R11: A write to address 2 only fills a buffer and leaves the count unchanged. A write to address 1 loads the whole count: in 16-bit mode the buffered high byte and the written low byte, in 8-bit mode the written byte with the upper byte zero.
- R12: A write to address 1 clears the prescaler's partial count. After an overflow the count carries on from zero and does not return to the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_rd | input | 1 | Read strobe (with bus_sel); required for the high-byte capture |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data for the addressed register (combinational) |
| ext_evt | input | 1 | Asynchronous event pin |
| irq | output | 1 | Interrupt request |

## Verification
The case that is hardest to reach from the ports is the 16-bit wrap. From a zero start it needs 65536 prescaled pulses. The bench instead preloads 0xFFFE through the buffered high byte followed by the low byte, runs the internal time base with the prescaler bypassed, and gets the flag within a few ticks. The same sequence also tests whether the high-byte write alone has left the count untouched. A model in the bench mirrors the synchroniser delay, the time-base phase and the prescaler phase on every clock, so that each read and each interrupt level is compared at the exact cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_CLO  = 2'd1,
      A_CHI  = 2'd2,
      A_STAT = 2'd3
   } tmr_addr_e;

   // Control byte, MSB first: ps_sel[7:5] bypass[4] fall[3] ext[2] wide[1] run[0]
   typedef struct packed {
      logic [2:0] ps_sel;
      logic       ps_bypass;
      logic       fall_edge;
      logic       src_ext;
      logic       wide;
      logic       run;
   } tmr_ctrl_t;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall,
   output logic pulse
);
   logic [STAGES:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n) q[0] <= 1'b0;
      else        q[0] <= pin;
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= q[i-1];
      end
   end

   assign pulse = fall ? (~q[STAGES-1] &  q[STAGES])
                       : ( q[STAGES-1] & ~q[STAGES]);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_pulse,
   input  logic             bypass,
   input  logic [SEL_W-1:0] sel,
   output logic             out_pulse
);
   localparam int PS_W = 1 << SEL_W;

   logic [PS_W-1:0] psc_q;
   logic [PS_W-1:0] mask;

   for (genvar i = 0; i < PS_W; i++) begin : g_mask
      assign mask[i] = (32'(i) <= 32'(sel));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        psc_q <= '0;
      else if (clr)      psc_q <= '0;
      else if (in_pulse) psc_q <= psc_q + 1'b1;
   end

   assign out_pulse = in_pulse & (bypass | ((psc_q & mask) == mask));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step,
   input  logic                wide,
   input  logic                ld,
   input  logic [2*BYTE_W-1:0] ld_val,
   output logic [2*BYTE_W-1:0] cnt,
   output logic                ovf
);
   localparam int CW = 2 * BYTE_W;

   logic at_max;
   assign at_max = wide ? (&cnt) : (&cnt[BYTE_W-1:0]);
   assign ovf    = step & ~ld & at_max;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (ld)      cnt <= ld_val;
      else if (step) begin
         if (wide) cnt <= cnt + 1'b1;
         else      cnt <= {{(CW-BYTE_W){1'b0}}, cnt[BYTE_W-1:0] + 1'b1};
      end
   end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [1:0]          bus_addr,
   input  logic [BYTE_W-1:0]   bus_wdata,
   output logic [BYTE_W-1:0]   bus_rdata,
   input  logic [2*BYTE_W-1:0] cnt,
   input  logic                ovf,
   output tmr_ctrl_t           ctrl,
   output logic                ie,
   output logic                flag,
   output logic                flag_clr,
   output logic                cnt_ld,
   output logic [2*BYTE_W-1:0] ld_val
);
   tmr_addr_e       addr;
   logic            wr_en;
   logic            rd_en;
   logic [BYTE_W-1:0] hi_wbuf;
   logic [BYTE_W-1:0] hi_rbuf;

   assign addr     = tmr_addr_e'(bus_addr);
   assign wr_en    = bus_sel & bus_wr;
   assign rd_en    = bus_sel & bus_rd;
   assign cnt_ld   = wr_en & (addr == A_CLO);
   assign flag_clr = wr_en & (addr == A_STAT) & bus_wdata[0];
   assign ld_val   = ctrl.wide ? {hi_wbuf, bus_wdata}
                               : {{BYTE_W{1'b0}}, bus_wdata};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl    <= '0;
         ie      <= 1'b0;
         hi_wbuf <= '0;
         hi_rbuf <= '0;
      end else begin
         if (wr_en && addr == A_CTRL) ctrl    <= tmr_ctrl_t'(bus_wdata[7:0]);
         if (wr_en && addr == A_STAT) ie      <= bus_wdata[1];
         if (wr_en && addr == A_CHI)  hi_wbuf <= bus_wdata;
         if (rd_en && addr == A_CLO)  hi_rbuf <= cnt[2*BYTE_W-1:BYTE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        flag <= 1'b0;
      else if (ovf)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   always_comb begin
      case (addr)
         A_CTRL:  bus_rdata = BYTE_W'(ctrl);
         A_CLO:   bus_rdata = cnt[BYTE_W-1:0];
         A_CHI:   bus_rdata = hi_rbuf;
         default: bus_rdata = BYTE_W'({ie, flag});
      endcase
   end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import tmr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int PS_SEL_W    = 3,
   parameter int SYNC_STAGES = 2,
   parameter int TB_DIV      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              ext_evt,
   output logic              irq
);
   localparam int CW  = 2 * BYTE_W;
   localparam int TBW = (TB_DIV > 2) ? $clog2(TB_DIV) : 1;

   if (BYTE_W < 8) begin : g_bad_byte
      $error("BYTE_W must hold the 8-bit control layout");
   end
   if (PS_SEL_W != 3) begin : g_bad_sel
      $error("PS_SEL_W must match the 3-bit control field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TB_DIV < 2) begin : g_bad_tb
      $error("TB_DIV must be at least 2");
   end

   tmr_ctrl_t     ctrl_q;
   logic          ie_q;
   logic          ovf_flag;
   logic          flag_clr;
   logic          cnt_ld;
   logic [CW-1:0] ld_val;
   logic [CW-1:0] cnt_q;
   logic          ovf;
   logic          ext_pulse;
   logic          tb_pulse;
   logic          src_pulse;
   logic          ps_pulse;
   logic          run_en;
   logic [TBW-1:0] tb_q;

   assign run_en = ctrl_q.run;

   always_ff @(posedge clk) begin
      if (!rst_n)        tb_q <= '0;
      else if (tb_pulse) tb_q <= '0;
      else               tb_q <= tb_q + 1'b1;
   end
   assign tb_pulse = (tb_q == TBW'(TB_DIV - 1));

   tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_evt),
      .fall  (ctrl_q.fall_edge),
      .pulse (ext_pulse)
   );

   assign src_pulse = run_en & (ctrl_q.src_ext ? ext_pulse : tb_pulse);

   tmr_prescale #(.SEL_W(PS_SEL_W)) u_psc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cnt_ld),
      .in_pulse  (src_pulse),
      .bypass    (ctrl_q.ps_bypass),
      .sel       (ctrl_q.ps_sel),
      .out_pulse (ps_pulse)
   );

   tmr_count #(.BYTE_W(BYTE_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (ps_pulse),
      .wide   (ctrl_q.wide),
      .ld     (cnt_ld),
      .ld_val (ld_val),
      .cnt    (cnt_q),
      .ovf    (ovf)
   );

   tmr_regs #(.BYTE_W(BYTE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cnt       (cnt_q),
      .ovf       (ovf),
      .ctrl      (ctrl_q),
      .ie        (ie_q),
      .flag      (ovf_flag),
      .flag_clr  (flag_clr),
      .cnt_ld    (cnt_ld),
      .ld_val    (ld_val)
   );

   assign irq = ovf_flag & ie_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          flag,
   input logic          clr,
   input logic          irq,
   input logic [CW-1:0] cnt,
   input logic          ld,
   input logic          run
);
   // R7: flag holds unless software clears it
   p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

   // R9: a stopped counter keeps its value
   p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld) |=> (cnt == $past(cnt)));

   // R5: without a load the count only holds, steps by one or wraps to zero
   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0));

   // R6: the flag only rises together with a wrap to zero
   p_flag_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (cnt == '0));

   // R8: no interrupt without a pending flag
   p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);
endmodule

bind evt_timer tmr_chk #(.CW(2*BYTE_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .flag  (ovf_flag),
   .clr   (flag_clr),
   .irq   (irq),
   .cnt   (cnt_q),
   .ld    (cnt_ld),
   .run   (run_en)
);

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       ext_evt = 1'b0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   evt_timer u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ext_evt(ext_evt), .irq(irq)
   );

   // ---------------- reference model ----------------
   bit q_ext[$];
   int m_ctrl, m_cnt, m_hiw, m_hir, m_psc, m_tb;
   bit m_flag, m_ie;

   always @(posedge clk) begin
      if (!rst_n) begin
         q_ext = '{0, 0, 0};
         m_ctrl = 0; m_cnt = 0; m_hiw = 0; m_hir = 0; m_psc = 0; m_tb = 0;
         m_flag = 0; m_ie = 0;
      end else begin
         bit cur, prv, edge_hit, tbp, src, step, ovf, wr, rd, wide;
         int ratio;
         q_ext.push_back(ext_evt);
         while (q_ext.size() > 4) void'(q_ext.pop_front());
         cur = q_ext[q_ext.size()-3];
         prv = q_ext[q_ext.size()-4];
         edge_hit = m_ctrl[3] ? (!cur && prv) : (cur && !prv);
         tbp = (m_tb == 3);
         m_tb = (m_tb + 1) % 4;
         src = m_ctrl[0] && (m_ctrl[2] ? edge_hit : tbp);
         ratio = 1 << (((m_ctrl >> 5) & 7) + 1);
         step = src && (m_ctrl[4] || (m_psc % ratio) == ratio - 1);
         wr = bus_sel && bus_wr;
         rd = bus_sel && bus_rd;
         wide = m_ctrl[1];
         ovf = 0;
         if (rd && bus_addr == 2'd1) m_hir = (m_cnt >> 8) & 255;
         if (wr && bus_addr == 2'd1) begin
            m_cnt = wide ? ((m_hiw << 8) | bus_wdata) : bus_wdata;
            m_psc = 0;
         end else begin
            if (src) m_psc = (m_psc + 1) % 256;
            if (step) begin
               if (wide) begin
                  ovf = (m_cnt == 65535);
                  m_cnt = (m_cnt + 1) % 65536;
               end else begin
                  ovf = ((m_cnt & 255) == 255);
                  m_cnt = ((m_cnt & 255) + 1) & 255;
               end
            end
         end
         if (ovf) m_flag = 1;
         else if (wr && bus_addr == 2'd3 && bus_wdata[0]) m_flag = 0;
         if (wr && bus_addr == 2'd3) m_ie = bus_wdata[1];
         if (wr && bus_addr == 2'd2) m_hiw = bus_wdata;
         if (wr && bus_addr == 2'd0) m_ctrl = bus_wdata;
      end
   end

   // R8: interrupt level compared on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (irq !== (m_flag && m_ie)) begin
            errors++;
            $display("FAIL R8 irq actual %0b expected %0b", irq, m_flag && m_ie);
         end
      end
   end

   function automatic int m_view(input int a);
      case (a)
         0: return m_ctrl;
         1: return m_cnt & 255;
         2: return m_hir;
         default: return (int'(m_ie) << 1) | int'(m_flag);
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   // read, compare with the model, return the value seen
   task automatic rd(input int a, input string req, output int v);
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_addr = 2'(a);
      #1;
      v = bus_rdata;
      chk(req, v, m_view(a));
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_evt = 1; idle(3);
         ext_evt = 0; idle(3);
      end
   endtask

   initial begin
      int v, v2;
      idle(3);
      rst_n = 1;
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(a, "R1", v);
         chk("R1 zero", v, 0);
      end
      chk("R1 irq", int'(irq), 0);

      // R3 internal time base, bypass, 8-bit
      wr(0, 8'h11);
      wr(1, 0);
      idle(41);
      rd(1, "R3", v);
      chk("R3 range", int'(v >= 9 && v <= 12), 1);

      // R4 prescaler 1:4, load clears partial count (R12)
      wr(0, 8'h21);
      wr(1, 0);
      idle(83);
      rd(1, "R4", v);
      chk("R4 range", int'(v >= 4 && v <= 6), 1);
      wr(0, 8'he1); // 1:256
      wr(1, 0);
      idle(50);
      rd(1, "R4 slow", v);
      chk("R4 slow zero", v, 0);

      // R5 8-bit wrap from preset, R8 interrupt, R12 no reload
      wr(3, 2);
      wr(0, 8'h11);
      wr(1, 253);
      idle(20);
      chk("R5 irq after wrap", int'(irq), 1);
      rd(3, "R5 flag", v);
      chk("R5 flag bit", v & 1, 1);
      rd(1, "R12 no reload", v);
      chk("R12 below preset", int'(v < 253), 1);
      // R7 sticky then clear
      idle(10);
      rd(3, "R7 sticky", v);
      chk("R7 still set", v & 1, 1);
      wr(3, 3);
      rd(3, "R7 cleared", v);
      chk("R7 bit0", v & 1, 0);
      // R8 disable gating
      wr(1, 254);
      wr(3, 0);
      idle(20);
      chk("R8 masked", int'(irq), 0);
      rd(3, "R8 flag pending", v);
      chk("R8 flag bit", v, 1);
      wr(3, 1);

      // R9 stop
      wr(0, 8'h10);
      rd(1, "R9 a", v);
      idle(30);
      rd(1, "R9 b", v2);
      chk("R9 held", v2, v);

      // R11/R6/R10 16-bit path
      wr(0, 8'h12);
      wr(1, 8'h40);
      wr(2, 8'hff);
      rd(1, "R11 hi write buffered", v);
      chk("R11 low unchanged", v, 8'h40);
      rd(2, "R11 hi unchanged", v);
      chk("R11 hi zero", v, 0);
      wr(1, 8'hfe);
      rd(1, "R10 low", v);
      chk("R10 low val", v, 8'hfe);
      rd(2, "R10 hi", v);
      chk("R10 hi val", v, 8'hff);
      wr(3, 2);
      wr(0, 8'h13);
      idle(20);
      chk("R6 irq", int'(irq), 1);
      rd(1, "R6 low", v);
      rd(2, "R6 hi", v);
      chk("R6 hi wrapped", v, 0);
      wr(3, 1);

      // R2 external rising then falling
      wr(0, 8'h15);
      wr(1, 0);
      pulses(5);
      idle(6);
      rd(1, "R2 rising", v);
      chk("R2 rising count", v, 5);
      wr(0, 8'h1d);
      wr(1, 0);
      pulses(3);
      idle(6);
      rd(1, "R2 falling", v);
      chk("R2 falling count", v, 3);
      // R2 with prescale 1:2
      wr(0, 8'h05);
      wr(1, 0);
      pulses(6);
      idle(6);
      rd(1, "R2 prescaled", v);
      chk("R2 prescaled count", v, 3);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule